// File: doc/BRIEF.md
# Multi-Channel Compare Event Timer

This block holds one 64-bit up-counter and a set of comparator channels that watch it. While the global run bit is set, the counter advances by one each clock and never stops or counts down. Each channel holds a 64-bit target. When the counter equals that target, the channel raises an event. A channel in one-shot mode leaves its target as it is. A periodic-capable channel in periodic mode adds its stored period to the target after every match, so that events recur at a fixed spacing.

Software reaches everything through a word-wide register port with separate read and write strobes. This port covers the capability words, the global run bit, the shared status word, both halves of the counter, and per channel a configuration word, a target and a period. Each channel's interrupt line is driven in one of two ways. In pulse mode it gives a single-cycle pulse per event. In level mode it follows a sticky status bit, which is cleared by writing 1 to it. A channel can also be narrowed to 32 bits: it then compares only the low halves, and it also fires when the low half of the counter rolls over.

Register map, word addresses: 0 tick period in femtoseconds (read-only), 1 channel count (read-only), 2 run control (bit 0), 3 status (bit n is channel n, write 1 to clear), 4 and 5 counter low and high. Channel n sits at 16 + 8n, with these offsets: +0 configuration, +1 and +2 target low and high, +3 and +4 period low and high. Configuration bits: 1 level mode, 2 interrupt enable, 3 periodic, 4 periodic-capable (read-only), 5 narrow 32-bit mode.

Top module: `evt_timer`

## Requirements
- R1: While run (address 2, bit 0) is 1, the counter increases by exactly one per clock. While run is 0, the counter holds its value.
- R2: Writes to the counter words (addresses 4 and 5) take effect only while run is 0 and are ignored while it is 1. A read returns the value the addressed word held in the read cycle, on `rsp_rdata` one clock later; any cycle without a read gives 0.
- R3: In one-shot mode a channel fires when the counter equals its target, and its target does not change.
- R4: In periodic mode, each match adds the channel's period to its target. In narrow mode only the low 32 bits are added.
- R5: The periodic bit (bit 3) can be set only on channels marked capable by PER_MASK, and it reads 0 on all other channels. The capable bit (bit 4) is read-only and reports PER_MASK.
- R6: In pulse mode (bit 1 = 0), an event in the clock where the counter equals the target makes `irq` high for exactly the following clock.
- R7: In level mode (bit 1 = 1), an event sets the channel's status bit from the next clock on, and `irq` follows that bit. The bit stays set until software writes 1 to it at address 3; writing 0 has no effect. An event in the clear cycle keeps the bit set.
- R8: With the interrupt enable (bit 2) at 0, a channel produces neither an `irq` nor a status bit.
- R9: In narrow mode (bit 5), a channel compares only the low 32 bits. It also fires in the clock where the low 32 bits of the counter are all ones while running.
- R10: Address 0 reads TICK_FS and address 1 reads NUM_CH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_wr | input | 1 | Register write strobe |
| req_rd | input | 1 | Register read strobe |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data, one clock after `req_rd` |
| irq | output | NUM_CH | One interrupt line per channel |

## Verification
A match is decided on the counter value present before a clock edge. The interrupt pulse or the status bit appears just after that edge, so an event is due one clock after the counter equals the target. Register reads are likewise due one clock after the strobe. The bench drives stimulus on falling edges and updates its behavioural model on rising edges. It compares the `irq` lines on every falling edge and compares read data on the falling edge after each read, so each result is sampled exactly one register stage after its cause.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int DW = 32;
  localparam int CW = 64;
  // global word addresses
  localparam int A_CAP  = 0;
  localparam int A_NCH  = 1;
  localparam int A_RUN  = 2;
  localparam int A_STAT = 3;
  localparam int A_CLO  = 4;
  localparam int A_CHI  = 5;
  // channel windows
  localparam int CH_BASE   = 16;
  localparam int CH_STRIDE = 8;
  localparam int O_CFG  = 0;
  localparam int O_CMPL = 1;
  localparam int O_CMPH = 2;
  localparam int O_PERL = 3;
  localparam int O_PERH = 4;
  // configuration bits
  localparam int B_LVL = 1;
  localparam int B_IEN = 2;
  localparam int B_PER = 3;
  localparam int B_CAP = 4;
  localparam int B_N32 = 5;
endpackage

// File: rtl/evt_counter.sv
module evt_counter
  import evt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic          roll32
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end else begin
      if (wr_lo) cnt[DW-1:0]  <= wdata;
      if (wr_hi) cnt[CW-1:DW] <= wdata;
    end
  end

  assign roll32 = run && (cnt[DW-1:0] == {DW{1'b1}});

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    run |=> cnt == $past(cnt) + 1'b1); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_lo && !wr_hi) |=> $stable(cnt)); // R1
  AST_CNT_WR_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (run && (wr_lo || wr_hi)) |=> cnt == $past(cnt) + 1'b1); // R2
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_pkg::*;
#(
  parameter bit PER_CAP = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] cnt,
  input  logic          roll32,
  input  logic          wr_cfg,
  input  logic          wr_cmpl,
  input  logic          wr_cmph,
  input  logic          wr_perl,
  input  logic          wr_perh,
  input  logic [DW-1:0] wdata,
  input  logic          stat_clr,
  output logic [DW-1:0] cfg_rd,
  output logic [CW-1:0] cmp,
  output logic [CW-1:0] per,
  output logic          status,
  output logic          irq
);
  logic lvl, ien, per_en, n32, pulse;
  logic match, evt, cmp_wr;

  assign match  = run && (n32 ? (cnt[DW-1:0] == cmp[DW-1:0]) : (cnt == cmp));
  assign evt    = ien && (match || (n32 && roll32));
  assign cmp_wr = wr_cmpl || wr_cmph;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= 1'b0; ien <= 1'b0; per_en <= 1'b0; n32 <= 1'b0;
    end else if (wr_cfg) begin
      lvl    <= wdata[B_LVL];
      ien    <= wdata[B_IEN];
      per_en <= wdata[B_PER] & PER_CAP;
      n32    <= wdata[B_N32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp <= '0;
      per <= '0;
    end else begin
      if (wr_perl) per[DW-1:0]  <= wdata;
      if (wr_perh) per[CW-1:DW] <= wdata;
      if (cmp_wr) begin
        if (wr_cmpl) cmp[DW-1:0]  <= wdata;
        if (wr_cmph) cmp[CW-1:DW] <= wdata;
      end else if (per_en && match) begin
        if (n32) cmp[DW-1:0] <= cmp[DW-1:0] + per[DW-1:0];
        else     cmp         <= cmp + per;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= 1'b0;
      pulse  <= 1'b0;
    end else begin
      pulse <= evt && !lvl;
      if (lvl && evt)    status <= 1'b1;
      else if (stat_clr) status <= 1'b0;
    end
  end

  assign irq    = lvl ? status : pulse;
  assign cfg_rd = {{(DW-6){1'b0}}, n32, PER_CAP, per_en, ien, lvl, 1'b0};

  AST_ONESHOT_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!per_en && !cmp_wr) |=> $stable(cmp)); // R3
  AST_PER_STEP: assert property (@(posedge clk) disable iff (rst)
    (per_en && !n32 && match && !cmp_wr) |=> cmp == $past(cmp) + $past(per)); // R4
  AST_LVL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (status && !stat_clr) |=> status); // R7
  AST_IEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!ien && !status) |=> (!status && !irq)); // R8
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_pkg::*;
#(
  parameter int          NUM_CH  = 3,
  parameter logic [31:0] TICK_FS = 32'd69841279,
  parameter logic [31:0] PER_MASK = 32'h0000_0003,
  parameter int          ADDR_W  = $clog2(CH_BASE + CH_STRIDE*NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic [DW-1:0]     rsp_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int SW = ADDR_W - 3;

  logic              run;
  logic [CW-1:0]     cnt;
  logic              roll32;
  logic [NUM_CH-1:0] stat;
  logic [DW-1:0]     cfg_rd [NUM_CH];
  logic [CW-1:0]     cmp_v  [NUM_CH];
  logic [CW-1:0]     per_v  [NUM_CH];
  logic [DW-1:0]     rd_mux;
  logic              wr_stat;

  assign wr_stat = req_wr && (req_addr == ADDR_W'(A_STAT));

  always_ff @(posedge clk) begin
    if (rst) run <= 1'b0;
    else if (req_wr && req_addr == ADDR_W'(A_RUN)) run <= req_wdata[0];
  end

  evt_counter u_cnt (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .wr_lo  (req_wr && req_addr == ADDR_W'(A_CLO)),
    .wr_hi  (req_wr && req_addr == ADDR_W'(A_CHI)),
    .wdata  (req_wdata),
    .cnt    (cnt),
    .roll32 (roll32)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic          sel;
    logic [2:0]    off;
    assign sel = req_wr && (req_addr[ADDR_W-1:3] == SW'(CH_BASE/CH_STRIDE + n));
    assign off = req_addr[2:0];

    evt_channel #(.PER_CAP(PER_MASK[n])) u_ch (
      .clk      (clk),
      .rst      (rst),
      .run      (run),
      .cnt      (cnt),
      .roll32   (roll32),
      .wr_cfg   (sel && off == 3'(O_CFG)),
      .wr_cmpl  (sel && off == 3'(O_CMPL)),
      .wr_cmph  (sel && off == 3'(O_CMPH)),
      .wr_perl  (sel && off == 3'(O_PERL)),
      .wr_perh  (sel && off == 3'(O_PERH)),
      .wdata    (req_wdata),
      .stat_clr (wr_stat && req_wdata[n]),
      .cfg_rd   (cfg_rd[n]),
      .cmp      (cmp_v[n]),
      .per      (per_v[n]),
      .status   (stat[n]),
      .irq      (irq[n])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (req_addr == ADDR_W'(A_CAP))  rd_mux = TICK_FS;
    if (req_addr == ADDR_W'(A_NCH))  rd_mux = DW'(NUM_CH);
    if (req_addr == ADDR_W'(A_RUN))  rd_mux = DW'(run);
    if (req_addr == ADDR_W'(A_STAT)) rd_mux = DW'(stat);
    if (req_addr == ADDR_W'(A_CLO))  rd_mux = cnt[DW-1:0];
    if (req_addr == ADDR_W'(A_CHI))  rd_mux = cnt[CW-1:DW];
    for (int n = 0; n < NUM_CH; n++) begin
      if (req_addr[ADDR_W-1:3] == SW'(CH_BASE/CH_STRIDE + n)) begin
        case (req_addr[2:0])
          3'(O_CFG):  rd_mux = cfg_rd[n];
          3'(O_CMPL): rd_mux = cmp_v[n][DW-1:0];
          3'(O_CMPH): rd_mux = cmp_v[n][CW-1:DW];
          3'(O_PERL): rd_mux = per_v[n][DW-1:0];
          3'(O_PERH): rd_mux = per_v[n][CW-1:DW];
          default:    rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rsp_rdata <= '0;
    else     rsp_rdata <= req_rd ? rd_mux : '0;
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !req_rd |=> rsp_rdata == '0); // R2
  AST_CAP_READ: assert property (@(posedge clk) disable iff (rst)
    (req_rd && req_addr == ADDR_W'(A_CAP)) |=> rsp_rdata == TICK_FS); // R10
endmodule

// File: tb/evt_timer_bench.sv
`timescale 1ns/1ps
module evt_timer_bench;
  localparam int NCH = 3;
  localparam logic [31:0] TFS = 32'd69841279;
  localparam logic [31:0] PMASK = 32'h3;
  localparam int AW = 6;
  localparam int CH0 = 16, CH1 = 24, CH2 = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic b_wr = 1'b0, b_rd = 1'b0;
  logic [AW-1:0] b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic [31:0] rsp_rdata;
  logic [NCH-1:0] irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evt_timer #(.NUM_CH(NCH), .TICK_FS(TFS), .PER_MASK(PMASK)) u_evt_timer (
    .clk(clk), .rst(rst), .req_wr(b_wr), .req_rd(b_rd), .req_addr(b_addr),
    .req_wdata(b_wdata), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  // behavioural reference model
  longint unsigned m_cnt;
  bit              m_run;
  longint unsigned m_cmp [NCH];
  longint unsigned m_per [NCH];
  bit m_lvl [NCH], m_ien [NCH], m_pen [NCH], m_n32 [NCH], m_st [NCH], m_pl [NCH];
  logic [NCH-1:0] m_irq;
  logic [31:0]    m_rd;

  function automatic logic [31:0] mread(input int a);
    logic [31:0] st;
    st = '0;
    for (int n = 0; n < NCH; n++) st[n] = m_st[n];
    if (a == 0) return TFS;
    if (a == 1) return NCH;
    if (a == 2) return {31'd0, m_run};
    if (a == 3) return st;
    if (a == 4) return m_cnt[31:0];
    if (a == 5) return m_cnt[63:32];
    for (int n = 0; n < NCH; n++) begin
      if (a == 16 + 8*n)     return {26'd0, m_n32[n], PMASK[n], m_pen[n], m_ien[n], m_lvl[n], 1'b0};
      if (a == 16 + 8*n + 1) return m_cmp[n][31:0];
      if (a == 16 + 8*n + 2) return m_cmp[n][63:32];
      if (a == 16 + 8*n + 3) return m_per[n][31:0];
      if (a == 16 + 8*n + 4) return m_per[n][63:32];
    end
    return '0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_run = 0; m_irq = '0; m_rd = '0;
      for (int n = 0; n < NCH; n++) begin
        m_cmp[n] = 0; m_per[n] = 0; m_lvl[n] = 0; m_ien[n] = 0;
        m_pen[n] = 0; m_n32[n] = 0; m_st[n] = 0; m_pl[n] = 0;
      end
    end else begin
      int a;
      bit hit, ev, roll;
      a = int'(b_addr);
      m_rd = b_rd ? mread(a) : 32'd0;
      roll = m_run && (m_cnt[31:0] == 32'hFFFF_FFFF);
      for (int n = 0; n < NCH; n++) begin
        hit = m_run && (m_n32[n] ? (m_cnt[31:0] == m_cmp[n][31:0]) : (m_cnt == m_cmp[n]));
        ev  = m_ien[n] && (hit || (m_n32[n] && roll));
        m_pl[n] = ev && !m_lvl[n];
        if (m_lvl[n] && ev) m_st[n] = 1;
        else if (b_wr && a == 3 && b_wdata[n]) m_st[n] = 0;
        if (b_wr && (a == 16+8*n+1 || a == 16+8*n+2)) begin
          if (a == 16+8*n+1) m_cmp[n][31:0]  = b_wdata;
          else               m_cmp[n][63:32] = b_wdata;
        end else if (m_pen[n] && hit) begin
          if (m_n32[n]) m_cmp[n][31:0] = m_cmp[n][31:0] + m_per[n][31:0];
          else          m_cmp[n] = m_cmp[n] + m_per[n];
        end
        if (b_wr && a == 16+8*n+3) m_per[n][31:0]  = b_wdata;
        if (b_wr && a == 16+8*n+4) m_per[n][63:32] = b_wdata;
        if (b_wr && a == 16+8*n) begin
          m_lvl[n] = b_wdata[1]; m_ien[n] = b_wdata[2];
          m_pen[n] = b_wdata[3] && PMASK[n]; m_n32[n] = b_wdata[5];
        end
      end
      if (m_run) m_cnt = m_cnt + 1;
      else begin
        if (b_wr && a == 4) m_cnt[31:0]  = b_wdata;
        if (b_wr && a == 5) m_cnt[63:32] = b_wdata;
      end
      if (b_wr && a == 2) m_run = b_wdata[0];
      for (int n = 0; n < NCH; n++) m_irq[n] = m_lvl[n] ? m_st[n] : m_pl[n];
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle interrupt comparison
  int pulses2 = 0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R3 R6 R7 R8 R9 irq lines", 64'(irq), 64'(m_irq));
      pulses2 += int'(irq[2]);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    b_wr = 1'b1; b_addr = AW'(a); b_wdata = d;
    @(negedge clk);
    b_wr = 1'b0;
  endtask

  task automatic rd(input int a, input string tag, output logic [31:0] v);
    @(negedge clk);
    b_rd = 1'b1; b_addr = AW'(a);
    @(negedge clk);
    b_rd = 1'b0;
    check(tag, 64'(rsp_rdata), 64'(m_rd));
    v = rsp_rdata;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, c1, c2;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R2 reset read data", 64'(rsp_rdata), 64'd0);
    check("R1 reset irq", 64'(irq), 64'd0);
    rd(0, "R10 tick period", v);   check("R10 tick period value", 64'(v), 64'(TFS));
    rd(1, "R10 channel count", v); check("R10 channel count value", 64'(v), 64'(NCH));

    // counter load while halted
    wr(4, 32'd100); wr(5, 32'd0);
    rd(4, "R2 counter low load", v); check("R2 counter low value", 64'(v), 64'd100);
    repeat (5) @(negedge clk);
    rd(4, "R1 halted hold", v);     check("R1 halted value", 64'(v), 64'd100);

    // capability and periodic bit
    wr(CH2, 32'h8);
    rd(CH2, "R5 uncapable cfg", v); check("R5 periodic bit stays 0", 64'(v[4:3]), 64'd0);
    wr(CH0 + 0, 32'h18);
    rd(CH0, "R5 capable cfg", v);   check("R5 capable and periodic", 64'(v[4:3]), 64'd3);

    // channel setup
    wr(CH0 + 1, 32'd120); wr(CH0 + 2, 32'd0); wr(CH0, 32'h04);        // pulse, one-shot
    wr(CH1 + 1, 32'd110); wr(CH1 + 3, 32'd7); wr(CH1, 32'h0E);        // level, periodic
    wr(CH2 + 1, 32'd105); wr(CH2, 32'h00);                            // disabled
    wr(2, 32'd1);
    wr(4, 32'd5);                                                     // ignored while running
    repeat (40) @(negedge clk);
    rd(4, "R2 counter while running", v);
    rd(3, "R7 status sticky", v);   check("R7 channel1 status set", 64'(v[1]), 64'd1);
    check("R8 channel2 status clear", 64'(v[2]), 64'd0);
    wr(3, 32'd0);
    rd(3, "R7 write zero no effect", v); check("R7 still set", 64'(v[1]), 64'd1);
    wr(3, 32'h2);
    rd(3, "R7 cleared", v);
    repeat (30) @(negedge clk);
    rd(CH1 + 1, "R4 periodic target", c1);
    repeat (20) @(negedge clk);
    rd(CH1 + 1, "R4 periodic target later", c2);
    check("R4 target advanced by period multiple", 64'((c2 - c1) % 7), 64'd0);
    rd(CH0 + 1, "R3 one-shot target", v); check("R3 target unchanged", 64'(v), 64'd120);

    // narrow mode with low-half rollover
    wr(2, 32'd0);
    wr(4, 32'hFFFF_FFF0); wr(5, 32'd0);
    wr(CH2 + 1, 32'd3); wr(CH2 + 2, 32'd5); wr(CH2, 32'h24);
    pulses2 = 0;
    wr(2, 32'd1);
    repeat (30) @(negedge clk);
    check("R9 rollover and low match pulses", 64'(pulses2), 64'd2);
    rd(5, "R1 counter high after rollover", v); check("R1 carry into high", 64'(v), 64'd1);
    rd(CH2, "R9 narrow cfg", v);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule